// File: doc/BRIEF.md
# Virtually indexed, physically tagged cache lookup

This block performs the hit/miss decision for a small direct-mapped cache. The cache is indexed with virtual address bits and tagged with physical page numbers. Each request carries a virtual address and an address-space identifier. The low part of the address is the page offset. It passes to the physical address unchanged. The upper part is the virtual page number. A small fully associative translation buffer maps the page number to a physical page number.

The set index and the line offset sit wholly inside the page offset. Because of this, the tag/valid array is read with the untranslated address while translation runs in parallel. The same placement means that two virtual pages mapped to one physical page always select the same line. The translated page number is then compared with the stored tag. The result is registered, so a request presented in one cycle has its answer in the next.

Translation entries and cache tags are loaded through two simple fill ports. Data storage, page-table walking and refill policy belong to other blocks.

Top module: `vipt_lookup`

## Requirements
- R1: After reset, no translation entry and no cache line is valid. `rsp_valid` is 0, and any lookup reports `rsp_tlb_miss`=1 and `rsp_hit`=0.
- R2: The response outputs reflect the request presented one cycle earlier. `rsp_valid` is `req_valid` delayed by one cycle.
- R3: `rsp_pa[OFF_W-1:0]` equals the page-offset bits of the request address. With the defaults, this is bits [11:0].
- R4: On a translation hit, `rsp_pa[PA_W-1:OFF_W]` is the physical page number of the one entry whose virtual page number (address bits [31:12]) and identifier both equal the request.
- R5: If no valid entry matches, `rsp_tlb_miss` is 1, `rsp_hit` is 0 and the upper bits of `rsp_pa` are zero, whatever the tag array holds.
- R6: `rsp_hit` is 1 only when three conditions hold: translation hit, the indexed line is valid, and the line's stored tag equals the translated page number.
- R7: The set index is address bits [11:6], taken from the page offset. Two virtual pages that translate to the same physical page hit the same line.
- R8: A tag fill with `tag_fill_valid`=0 invalidates the line. A later lookup of that line misses, while its translation is still reported.
- R9: A translation fill whose page number and identifier match an existing entry overwrites that entry in place. Otherwise, the fill goes to the lowest-numbered invalid entry.
- R10: When all entries are valid and the fill matches none, the victim is chosen round-robin. The victim index starts at 0 after reset and advances by one (modulo the entry count) after each such replacement only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | VA_W | Virtual address of the request |
| req_asid | input | ASID_W | Address-space identifier of the request |
| tlb_fill_en | input | 1 | Write one translation entry |
| tlb_fill_vpn | input | VA_W-OFF_W | Virtual page number to store |
| tlb_fill_asid | input | ASID_W | Identifier to store |
| tlb_fill_ppn | input | PPN_W | Physical page number to store |
| tag_fill_en | input | 1 | Write one tag line |
| tag_fill_idx | input | IDX_W | Line to write |
| tag_fill_ppn | input | PPN_W | Physical tag to store |
| tag_fill_valid | input | 1 | Valid bit to store |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Cache hit |
| rsp_tlb_miss | output | 1 | No translation found |
| rsp_pa | output | PPN_W+OFF_W | Physical address |

## Verification
The hardest cases to reach are the translation-buffer replacement paths. An overwrite in place must not move the round-robin victim, while a replacement into a full buffer must. The stimulus first fills every entry. It then refills an existing page/identifier pair and follows with two fills of new pages. After each step, a lookup of each page shows which entry was lost. A second hard case is a translation that succeeds while the tag compare fails: the same virtual page under another identifier, pointing at a line tagged with a different physical page.

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int LINE_W = 6,
  parameter int IDX_W  = 6,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int TLB_N  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [VA_W-1:0]         req_va,
  input  logic [ASID_W-1:0]       req_asid,
  input  logic                    tlb_fill_en,
  input  logic [VA_W-OFF_W-1:0]   tlb_fill_vpn,
  input  logic [ASID_W-1:0]       tlb_fill_asid,
  input  logic [PPN_W-1:0]        tlb_fill_ppn,
  input  logic                    tag_fill_en,
  input  logic [IDX_W-1:0]        tag_fill_idx,
  input  logic [PPN_W-1:0]        tag_fill_ppn,
  input  logic                    tag_fill_valid,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic                    rsp_tlb_miss,
  output logic [PPN_W+OFF_W-1:0]  rsp_pa
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int PTR_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  logic [TLB_N-1:0]  t_vld;
  logic [VPN_W-1:0]  t_vpn  [TLB_N];
  logic [ASID_W-1:0] t_asid [TLB_N];
  logic [PPN_W-1:0]  t_ppn  [TLB_N];
  logic [SETS-1:0]   l_vld;
  logic [PPN_W-1:0]  l_tag  [SETS];
  logic [PTR_W-1:0]  rr;

  wire [VPN_W-1:0] vpn = req_va[VA_W-1:OFF_W];
  wire [IDX_W-1:0] idx = req_va[LINE_W+IDX_W-1:LINE_W];

  logic [TLB_N-1:0] hit_vec, fill_vec;
  logic [PPN_W-1:0] xl_ppn;
  logic [PTR_W-1:0] slot;
  logic             repl;

  for (genvar i = 0; i < TLB_N; i++) begin : g_cmp
    assign hit_vec[i]  = t_vld[i] && t_vpn[i] == vpn && t_asid[i] == req_asid;
    assign fill_vec[i] = t_vld[i] && t_vpn[i] == tlb_fill_vpn && t_asid[i] == tlb_fill_asid;
  end

  always_comb begin
    xl_ppn = '0;
    for (int i = 0; i < TLB_N; i++)
      if (hit_vec[i]) xl_ppn = xl_ppn | t_ppn[i];
  end

  always_comb begin
    slot = rr;
    repl = 1'b0;
    if (|fill_vec) begin
      for (int i = TLB_N - 1; i >= 0; i--)
        if (fill_vec[i]) slot = PTR_W'(i);
    end else if (!(&t_vld)) begin
      for (int i = TLB_N - 1; i >= 0; i--)
        if (!t_vld[i]) slot = PTR_W'(i);
    end else begin
      repl = 1'b1;
    end
  end

  wire xl_hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_vld        <= '0;
      l_vld        <= '0;
      rr           <= '0;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_tlb_miss <= 1'b0;
      rsp_pa       <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_hit      <= xl_hit && l_vld[idx] && l_tag[idx] == xl_ppn;
      rsp_tlb_miss <= !xl_hit;
      rsp_pa       <= {xl_ppn, req_va[OFF_W-1:0]};
      if (tlb_fill_en) begin
        t_vld[slot] <= 1'b1;
        if (repl) rr <= (rr == PTR_W'(TLB_N - 1)) ? '0 : rr + 1'b1;
      end
      if (tag_fill_en) l_vld[tag_fill_idx] <= tag_fill_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (tlb_fill_en) begin
      t_vpn[slot]  <= tlb_fill_vpn;
      t_asid[slot] <= tlb_fill_asid;
      t_ppn[slot]  <= tlb_fill_ppn;
    end
    if (tag_fill_en) l_tag[tag_fill_idx] <= tag_fill_ppn;
  end

  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0]));
  p_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  p_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_tlb_miss |-> !rsp_hit && rsp_pa[PPN_W+OFF_W-1:OFF_W] == '0);
  p_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> $past(l_vld[idx]));
endmodule

// File: tb/tb_vipt_lookup.sv
module tb_vipt_lookup;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [31:0] req_va = 0;
  logic [7:0] req_asid = 0;
  logic tlb_fill_en = 0;
  logic [19:0] tlb_fill_vpn = 0;
  logic [7:0] tlb_fill_asid = 0;
  logic [19:0] tlb_fill_ppn = 0;
  logic tag_fill_en = 0;
  logic [5:0] tag_fill_idx = 0;
  logic [19:0] tag_fill_ppn = 0;
  logic tag_fill_valid = 0;
  logic rsp_valid, rsp_hit, rsp_tlb_miss;
  logic [31:0] rsp_pa;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vipt_lookup dut (.*);

  // {va[32], asid[8], hit, tlb_miss, ppn[20]}
  localparam logic [61:0] VEC [8] = '{
    {32'h0001_0140, 8'd1, 1'b1, 1'b0, 20'h00A00},
    {32'h0001_1144, 8'd1, 1'b1, 1'b0, 20'h00A00},
    {32'h0001_0180, 8'd2, 1'b1, 1'b0, 20'h00B00},
    {32'h0001_0140, 8'd2, 1'b0, 1'b0, 20'h00B00},
    {32'h0001_0140, 8'd3, 1'b0, 1'b1, 20'h00000},
    {32'h0002_01C0, 8'd1, 1'b1, 1'b0, 20'h00C00},
    {32'h0002_0200, 8'd1, 1'b0, 1'b0, 20'h00C00},
    {32'h0003_0140, 8'd1, 1'b0, 1'b1, 20'h00000}
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic look(logic [31:0] va, logic [7:0] asid);
    @(negedge clk); req_valid = 1; req_va = va; req_asid = asid;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic expect_rsp(string req, logic [31:0] va, logic hit, logic miss, logic [19:0] ppn);
    chk(req, {63'd0, rsp_valid}, 64'd1);
    chk(req, {62'd0, rsp_hit, rsp_tlb_miss}, {62'd0, hit, miss});
    chk(req, {32'd0, rsp_pa}, {32'd0, ppn, va[11:0]});
  endtask

  task automatic tfill(logic [19:0] vpn, logic [7:0] asid, logic [19:0] ppn);
    @(negedge clk); tlb_fill_en = 1; tlb_fill_vpn = vpn; tlb_fill_asid = asid; tlb_fill_ppn = ppn;
    @(negedge clk); tlb_fill_en = 0;
  endtask

  task automatic lfill(logic [5:0] idx, logic [19:0] ppn, logic v);
    @(negedge clk); tag_fill_en = 1; tag_fill_idx = idx; tag_fill_ppn = ppn; tag_fill_valid = v;
    @(negedge clk); tag_fill_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    look(32'h0001_0140, 8'd1);
    expect_rsp("R1 empty lookup", 32'h0001_0140, 0, 1, 20'h0);
    @(negedge clk);
    chk("R2 idle strobe", {63'd0, rsp_valid}, 64'd0);

    tfill(20'h00010, 8'd1, 20'h00A00);
    tfill(20'h00011, 8'd1, 20'h00A00);
    tfill(20'h00010, 8'd2, 20'h00B00);
    tfill(20'h00020, 8'd1, 20'h00C00);
    lfill(6'd5, 20'h00A00, 1);
    lfill(6'd6, 20'h00B00, 1);
    lfill(6'd7, 20'h00C00, 1);

    for (int i = 0; i < 8; i++) begin
      look(VEC[i][61:30], VEC[i][29:22]);
      expect_rsp($sformatf("R4 R5 R6 R7 vector %0d", i), VEC[i][61:30],
                 VEC[i][21], VEC[i][20], VEC[i][19:0]);
    end

    lfill(6'd7, 20'h00C00, 0);
    look(32'h0002_01C0, 8'd1);
    expect_rsp("R8 invalidated line", 32'h0002_01C0, 0, 0, 20'h00C00);

    tfill(20'h00010, 8'd1, 20'h00B00);
    look(32'h0001_0180, 8'd1);
    expect_rsp("R9 overwrite in place", 32'h0001_0180, 1, 0, 20'h00B00);
    look(32'h0002_0040, 8'd1);
    expect_rsp("R9 others kept", 32'h0002_0040, 0, 0, 20'h00C00);

    tfill(20'h00040, 8'd1, 20'h00D00);
    look(32'h0001_0180, 8'd1);
    expect_rsp("R10 first victim entry 0", 32'h0001_0180, 0, 1, 20'h0);
    look(32'h0004_0000, 8'd1);
    expect_rsp("R10 new entry", 32'h0004_0000, 0, 0, 20'h00D00);
    look(32'h0001_1000, 8'd1);
    expect_rsp("R10 entry 1 kept", 32'h0001_1000, 0, 0, 20'h00A00);

    tfill(20'h00041, 8'd1, 20'h00E00);
    look(32'h0001_1000, 8'd1);
    expect_rsp("R10 second victim entry 1", 32'h0001_1000, 0, 1, 20'h0);
    look(32'h0001_0180, 8'd2);
    expect_rsp("R10 entry 2 kept", 32'h0001_0180, 1, 0, 20'h00B00);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule